// File: doc/BRIEF.md
# Module clock stop controller

This block holds the per-module clock stop requests for a large set of peripheral modules, 32 modules per register, and reports back whether each module's clock has actually stopped. Software reaches it over a plain single-cycle 32-bit register port. To stop or restart one module, software reads the control word, flips one bit and writes the whole word back. A set bit means "stop this clock". After clearing a bit to restart a module, software polls the matching status bit until it reads 0, and gives up after roughly a thousand polls.

There are two control banks. The system bank drives `clk_stop_req`. A second realtime bank sits 0x20 below each system control word and drives `rt_stop_req` on its own. Each module returns a stop acknowledge line, which passes through a two-flop synchronizer into the read-only status bank. Every control bit comes out of reset at 1, so every module starts stopped.

Top module: `modclk_stop_ctrl`

## Requirements
- R1: Module number n is controlled by bit n%32 of control word n/32, and drives `clk_stop_req[n]` (`rt_stop_req[n]` for the realtime bank). Its status is bit n%32 of status word n/32, taken from `stop_ack[n]`.
- R2: After a synchronous active-low reset, every system and realtime control bit is 1, and so are both request outputs. The synchronized status bits also reset to 1.
- R3: A write to a control word replaces all 32 bits at the clock edge where `bus_we` is sampled high. The request outputs show the new value right after that edge.
- R4: A read (`bus_re` high) of a control word returns, in the same cycle, the last value written to it.
- R5: System control word i is at byte address 0x130 + 4*i for i in 0..7, and at 0x990 + 4*(i-8) for i in 8..11.
- R6: Realtime control word i is at its system control address minus 0x20. Writes to it change only `rt_stop_req`, and writes to the system bank never change `rt_stop_req`.
- R7: Status word i is at 0x030 + 8*i for i in 0..3. Word 5 is at 0x03C and word 4 at 0x04C. Words 6 and 7 are at 0x1C0 and 0x1C4, and words 8..11 are at 0x9A0 + 4*(i-8).
- R8: A status bit reads 1 while the module reports stopped and 0 once it runs. It follows `stop_ack` exactly two clock edges later, which is far below the software poll limit.
- R9: Writes to status addresses are ignored. The status keeps following the acknowledge lines, and no control bit changes.
- R10: Reads of any address that matches no word return 0, and so does any read with `bus_re` low. Writes to such addresses change nothing. Addresses that are not word aligned count as unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| stop_ack | input | 32*NUM_REGS | Per-module stop acknowledge, 1 = clock stopped |
| clk_stop_req | output | 32*NUM_REGS | System-bank stop request per module |
| rt_stop_req | output | 32*NUM_REGS | Realtime-bank stop request per module |

## Verification
The bench checks the out-of-order status addresses, words 4 and 5 in particular. A decoder built from a monotonic formula would return the wrong module group there. It also exercises a single-bit read-modify-write: a bank that merged or masked bits would disturb the neighbours of the bit being changed. Another check confirms the two-edge acknowledge latency edge by edge, which catches both a missing and an extra synchronizer stage. The bench also writes to status, realtime, unmapped and misaligned addresses and confirms that each write touches only what it should.

// File: rtl/mcs_pkg.sv
// Shared constants and address map functions for the module clock stop controller.
// Assumes at most 12 control words; beyond that the upper control group
// would run into the upper status group.
package mcs_pkg;
    localparam int WORD_W  = 32;
    localparam int RT_DIST = 'h20;

    // System control word address for word i
    function automatic logic [11:0] ctl_off(input int i);
        if (i < 8) return 12'(('h130 + 4 * i));
        else       return 12'(('h990 + 4 * (i - 8)));
    endfunction

    // Realtime control word address for word i
    function automatic logic [11:0] rt_off(input int i);
        return 12'(ctl_off(i) - RT_DIST);
    endfunction

    // Status word address for word i; the low group is deliberately out of order
    function automatic logic [11:0] sts_off(input int i);
        if (i < 4)       return 12'(('h030 + 8 * i));
        else if (i == 4) return 12'h04C;
        else if (i == 5) return 12'h03C;
        else if (i < 8)  return 12'(('h1C0 + 4 * (i - 6)));
        else             return 12'(('h9A0 + 4 * (i - 8)));
    endfunction
endpackage

// File: rtl/mcs_addr_decode.sv
// Address decoder: sorts a byte address into the system control, realtime
// control or status bank, and gives the word index within that bank.
// Assumes the three bank maps do not overlap for NUM_REGS <= 12.
module mcs_addr_decode #(
    parameter int NUM_REGS = 12,
    parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [11:0]      addr,
    output logic             ctl_hit,
    output logic             rt_hit,
    output logic             sts_hit,
    output logic [IDX_W-1:0] idx
);
    import mcs_pkg::*;

    // Compare the address against every word address of every bank
    always_comb begin
        ctl_hit = 1'b0;
        rt_hit  = 1'b0;
        sts_hit = 1'b0;
        idx     = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ctl_off(i)) begin ctl_hit = 1'b1; idx = IDX_W'(i); end
            if (addr == rt_off(i))  begin rt_hit  = 1'b1; idx = IDX_W'(i); end
            if (addr == sts_off(i)) begin sts_hit = 1'b1; idx = IDX_W'(i); end
        end
    end

    // R5 R6 R7: an address never lands in two banks at once
    a_r7_bank_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_hit, rt_hit, sts_hit}));

    // R10: a misaligned address never hits any bank
    a_r10_misaligned_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[1:0] != 2'b00) |-> !(ctl_hit || rt_hit || sts_hit));
endmodule

// File: rtl/mcs_ctl_bank.sv
// Control register bank: NUM_REGS words of 32 bits, each written whole.
// Resets to all ones (all modules stopped). Assumes wr_idx < NUM_REGS when wr_en is high.
module mcs_ctl_bank #(
    parameter int NUM_REGS = 12,
    parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [31:0]                 wr_data,
    output logic [NUM_REGS-1:0][31:0]   words
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        // Hold one control word; a write replaces all 32 bits at once
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '1;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                words[g] <= wr_data;
        end
    end

    // R2: the bank is all ones in the cycle after reset
    a_r2_reset_ones: assert property (@(posedge clk)
        !rst_n |=> (&words));
endmodule

// File: rtl/mcs_ack_sync.sv
// Two-flop synchronizer bringing the per-module stop acknowledges into the
// block clock domain. Resets to ones to match the stopped state after reset.
module mcs_ack_sync #(
    parameter int WIDTH = 384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] ack_in,
    output logic [WIDTH-1:0] ack_sync
);
    logic [WIDTH-1:0] stage1;

    // Shift the acknowledge vector through two register stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '1;
            ack_sync <= '1;
        end else begin
            stage1   <= ack_in;
            ack_sync <= stage1;
        end
    end

    // Count edges since reset so the latency check never looks before reset
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    // R8: the output equals the input from exactly two edges earlier
    a_r8_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (ack_sync == $past(ack_in, 2)));
endmodule

// File: rtl/modclk_stop_ctrl.sv
// Module clock stop controller top. Holds a system and a realtime stop
// control bank, a synchronized status bank, and a single-cycle register port
// with same-cycle read data. Assumes 1 <= NUM_REGS <= 12 and at most one
// of bus_we / bus_re per cycle from the bus side.
module modclk_stop_ctrl #(
    parameter int NUM_REGS = 12,
    parameter int ADDR_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic                     bus_re,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [32*NUM_REGS-1:0]   stop_ack,
    output logic [32*NUM_REGS-1:0]   clk_stop_req,
    output logic [32*NUM_REGS-1:0]   rt_stop_req
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int NMOD  = 32 * NUM_REGS;

    logic             ctl_hit, rt_hit, sts_hit;
    logic [IDX_W-1:0] idx;
    logic [NUM_REGS-1:0][31:0] ctl_words, rt_words, sts_words;
    logic [NMOD-1:0]  ack_q;

    mcs_addr_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(12'(bus_addr)),
        .ctl_hit(ctl_hit), .rt_hit(rt_hit), .sts_hit(sts_hit), .idx(idx)
    );

    mcs_ctl_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_sys_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we && ctl_hit),
        .wr_idx(idx), .wr_data(bus_wdata), .words(ctl_words)
    );

    mcs_ctl_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rt_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we && rt_hit),
        .wr_idx(idx), .wr_data(bus_wdata), .words(rt_words)
    );

    mcs_ack_sync #(.WIDTH(NMOD)) u_sync (
        .clk(clk), .rst_n(rst_n), .ack_in(stop_ack), .ack_sync(ack_q)
    );

    // Module n sits at word n/32, bit n%32: the packed arrays flatten this way
    assign sts_words    = ack_q;
    assign clk_stop_req = ctl_words;
    assign rt_stop_req  = rt_words;

    // Same-cycle read mux; anything unmapped or unstrobed reads zero
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (ctl_hit)      bus_rdata = ctl_words[idx];
            else if (rt_hit)  bus_rdata = rt_words[idx];
            else if (sts_hit) bus_rdata = sts_words[idx];
        end
    end

    // R3: a control write lands whole in the addressed word at the next edge
    a_r3_word_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ctl_hit) |=> (clk_stop_req[32*$past(idx) +: 32] == $past(bus_wdata)));

    // R6: the realtime requests move only on a realtime write
    a_r6_rt_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && rt_hit) |=> $stable(rt_stop_req));

    // R9 R10: writes to status or unmapped addresses leave the system requests alone
    a_r9_no_side_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !ctl_hit) |=> $stable(clk_stop_req));

    // R10: reads that hit nothing return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !(ctl_hit || rt_hit || sts_hit)) |-> (bus_rdata == 32'h0));
endmodule

// File: tb/modclk_stop_ctrl_tb.sv
// Directed bench for the module clock stop controller; one task per scenario.
module modclk_stop_ctrl_tb;
    localparam int NR   = 12;
    localparam int NMOD = 32 * NR;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_we = 1'b0;
    logic            bus_re = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NMOD-1:0] stop_ack = '1;
    logic [NMOD-1:0] clk_stop_req;
    logic [NMOD-1:0] rt_stop_req;

    int n_tests = 0;
    int n_fail  = 0;

    modclk_stop_ctrl #(.NUM_REGS(NR), .ADDR_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stop_ack(stop_ack), .clk_stop_req(clk_stop_req), .rt_stop_req(rt_stop_req)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R2 sys requests", 64'(&clk_stop_req), 64'd1);
        check("R2 rt requests", 64'(&rt_stop_req), 64'd1);
        bus_read(12'h130, d); check("R2 ctl word0", 64'(d), 64'hFFFF_FFFF);
        bus_read(12'h9AC, d); check("R2 R8 status word11", 64'(d), 64'hFFFF_FFFF);
    endtask

    task automatic t_write_map;
        logic [31:0] d;
        bus_write(12'h13C, 32'hA5A5_0F0F);
        check("R3 word3 outputs", 64'(clk_stop_req[127:96]), 64'hA5A5_0F0F);
        check("R1 module 100", 64'(clk_stop_req[100]), 64'(1'b0));
        check("R1 module 96", 64'(clk_stop_req[96]), 64'(1'b1));
        bus_read(12'h13C, d); check("R4 word3 readback", 64'(d), 64'hA5A5_0F0F);
        bus_write(12'h994, 32'h1234_5678);
        check("R5 word9 outputs", 64'(clk_stop_req[319:288]), 64'h1234_5678);
        bus_read(12'h994, d); check("R4 R5 word9 readback", 64'(d), 64'h1234_5678);
        check("R3 word8 untouched", 64'(clk_stop_req[287:256]), 64'hFFFF_FFFF);
        bus_write(12'h14C, 32'h0000_0001);
        bus_read(12'h14C, d); check("R5 word7 readback", 64'(d), 64'h0000_0001);
    endtask

    task automatic t_rmw;
        logic [31:0] d;
        bus_read(12'h13C, d);
        d[0] = 1'b0;
        bus_write(12'h13C, d);
        check("R3 rmw module 96", 64'(clk_stop_req[96]), 64'(1'b0));
        check("R3 rmw neighbours", 64'(clk_stop_req[127:97]), 64'(31'h52D2_8787));
    endtask

    task automatic t_realtime;
        logic [31:0] d;
        logic [NMOD-1:0] sys_before;
        sys_before = clk_stop_req;
        bus_write(12'h11C, 32'h0F0F_0000);
        check("R6 rt word3 outputs", 64'(rt_stop_req[127:96]), 64'h0F0F_0000);
        check("R6 sys untouched", 64'(clk_stop_req == sys_before), 64'd1);
        bus_read(12'h11C, d); check("R6 R4 rt readback", 64'(d), 64'h0F0F_0000);
        bus_write(12'h130, 32'h0);
        check("R6 rt not moved by sys write", 64'(rt_stop_req[31:0]), 64'hFFFF_FFFF);
    endtask

    task automatic t_status;
        logic [31:0] d;
        for (int k = 0; k < NR; k++) stop_ack[32*k +: 32] = 32'h100 + 32'(k);
        repeat (3) @(posedge clk);
        bus_read(12'h04C, d); check("R7 status word4", 64'(d), 64'h104);
        bus_read(12'h03C, d); check("R7 status word5", 64'(d), 64'h105);
        bus_read(12'h038, d); check("R7 status word1", 64'(d), 64'h101);
        bus_read(12'h1C4, d); check("R7 status word7", 64'(d), 64'h107);
        bus_read(12'h9A8, d); check("R7 status word10", 64'(d), 64'h10A);
    endtask

    task automatic t_latency;
        @(negedge clk);
        stop_ack[159:128] = 32'h0000_0000;
        bus_re = 1'b1; bus_addr = 12'h04C;
        @(posedge clk); #1;
        check("R8 one edge still old", 64'(bus_rdata), 64'h104);
        @(posedge clk); #1;
        check("R8 two edges new", 64'(bus_rdata), 64'h0);
        bus_re = 1'b0;
    endtask

    task automatic t_ignored;
        logic [31:0] d;
        logic [NMOD-1:0] sys_before, rt_before;
        sys_before = clk_stop_req; rt_before = rt_stop_req;
        bus_write(12'h04C, 32'hDEAD_BEEF);
        bus_read(12'h04C, d); check("R9 status write ignored", 64'(d), 64'h0);
        check("R9 controls unchanged", 64'((clk_stop_req == sys_before) && (rt_stop_req == rt_before)), 64'd1);
        bus_write(12'h150, 32'h0);
        bus_write(12'h131, 32'h0);
        check("R10 unmapped write ignored", 64'((clk_stop_req == sys_before) && (rt_stop_req == rt_before)), 64'd1);
        bus_read(12'h034, d); check("R10 unmapped read", 64'(d), 64'h0);
        bus_read(12'h13D, d); check("R10 misaligned read", 64'(d), 64'h0);
        @(negedge clk); bus_addr = 12'h13C; #1;
        check("R10 read without strobe", 64'(bus_rdata), 64'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset;
        t_write_map;
        t_rmw;
        t_realtime;
        t_status;
        t_latency;
        t_ignored;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule